// File: doc/BRIEF.md
# Non-Destructive Inversion Memory Test Engine

This block is a built-in self-test sequencer for a synchronous single-port SRAM whose words carry ECC check bits. It finds stuck-at cells without destroying what the memory holds. Software sets a low and a high word address and pulses `start`. The engine walks upward through every word in that inclusive range. For each word it reads the whole stored word, including the check bits, and writes it back with every bit inverted. It then reads the word again and writes that second read back inverted. This double inversion returns the word to its original value.

Fault detection relies on the external ECC checker rather than on a compare against an expected pattern. Every bit cell is driven to both 0 and 1 during the sequence. A single stuck cell therefore makes one of the two reads look like a correctable error. The engine turns a raised correctable or uncorrectable flag during a read into a one-cycle error event that carries the word address and the error type. It then carries on with the sequence. The memory and the ECC encoder/decoder are outside the block.

Top module: `nd_inv_bist`

## Requirements
- R1: After `start` is accepted, the engine accesses each word address from `range_lo` to `range_hi` inclusive, in increasing order, and no address outside that range. `range_lo` and `range_hi` must be held stable while `busy` is high.
- R2: For each word the engine makes exactly four accesses to the same address, in the order read, write, read, write. They fall in cycles 0, 2, 3 and 5 of a six-cycle slot per word. Read data is taken one cycle after the read request.
- R3: Each write carries the bitwise inverse of the full `WORD_W`-bit word (data plus check bits) returned by the read just before it. The second write therefore inverts the second read, not the first.
- R4: When a run completes, every word in the range reads back the same value it held before the run, stuck cells included.
- R5: When `ecc_corr` or `ecc_uncorr` is high in the cycle where read data is taken, `err_valid` pulses for one cycle on the next cycle. `err_addr` then holds the word address, and `err_uncorr` is 1 if the uncorrectable flag was set and 0 if only the correctable flag was set. The sequence continues without a pause.
- R6: `busy` rises the cycle after `start` is accepted for a non-empty range. It stays high until `done` rises, and it is low while `done` is high. The memory enable is never high while `busy` is low.
- R7: `done` is a one-cycle pulse. For a range of N words it appears 6*N+1 cycles after the edge that accepts `start`. If `range_lo` > `range_hi`, it appears on the cycle after acceptance, and no memory access is made.
- R8: A `start` pulse while `busy` is high has no effect on the access sequence or on the timing of `done`.
- R9: While and after synchronous reset `rst`, `busy`, `done`, `mem_en` and `err_valid` are low.
- R10: A word with a single stuck-at cell produces exactly one correctable error event for that address during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| range_lo | input | ADDR_W | First word address tested |
| range_hi | input | ADDR_W | Last word address tested |
| busy | output | 1 | Test run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Write data, data plus check bits |
| mem_rdata | input | WORD_W | Read data, valid one cycle after a read |
| ecc_corr | input | 1 | Correctable-error flag for `mem_rdata` |
| ecc_uncorr | input | 1 | Uncorrectable-error flag for `mem_rdata` |
| err_valid | output | 1 | Error event strobe |
| err_uncorr | output | 1 | Event type: 1 uncorrectable, 0 correctable |
| err_addr | output | ADDR_W | Word address of the event |

## Verification
The engine is run against a triplicated-data code, where both a codeword and its inverse are valid. It is tried with the following cases:
- A clean range, which shows that the sequence alone raises no events.
- A stuck cell opposite to the stored bit, which makes the first read fail.
- A stuck cell equal to the stored bit, which moves the failure to the second read and so separates the two inversion phases.
- Two stuck cells in one word, which yield an uncorrectable event.

Several range shapes are also covered: inverted bounds, a single word at the top address, and the full memory. Together they separate the empty-range path, the last-word exit and the address stepping. A second `start` during a run shows that no extra accesses appear.

// File: rtl/nd_inv_pkg.sv
package nd_inv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_CAP1,
        ST_WR1,
        ST_RD2,
        ST_CAP2,
        ST_WR2,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic req;   // memory access this cycle
        logic wr;    // access is a write
        logic take;  // read data is valid this cycle
        logic busy;  // run in progress
        logic fin;   // end-of-run pulse
    } ctl_t;

    function automatic ctl_t decode_step(step_e s);
        ctl_t c;
        c = '0;
        case (s)
            ST_RD1, ST_RD2:   c.req  = 1'b1;
            ST_WR1, ST_WR2: begin
                c.req = 1'b1;
                c.wr  = 1'b1;
            end
            ST_CAP1, ST_CAP2: c.take = 1'b1;
            ST_DONE:          c.fin  = 1'b1;
            default:          c      = '0;
        endcase
        c.busy = (s != ST_IDLE) && (s != ST_DONE);
        return c;
    endfunction

endpackage

// File: rtl/nd_inv_addr.sv
module nd_inv_addr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= lo;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == hi);
endmodule

// File: rtl/nd_inv_fsm.sv
module nd_inv_fsm
    import nd_inv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  empty,
    input  logic  at_last,
    output step_e step,
    output ctl_t  ctl
);
    step_e nxt;

    always_comb begin
        nxt = step;
        case (step)
            ST_IDLE: if (start) nxt = empty ? ST_DONE : ST_RD1;
            ST_RD1:  nxt = ST_CAP1;
            ST_CAP1: nxt = ST_WR1;
            ST_WR1:  nxt = ST_RD2;
            ST_RD2:  nxt = ST_CAP2;
            ST_CAP2: nxt = ST_WR2;
            ST_WR2:  nxt = at_last ? ST_DONE : ST_RD1;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= ST_IDLE;
        else     step <= nxt;
    end

    assign ctl = decode_step(step);
endmodule

// File: rtl/nd_inv_dpath.sv
module nd_inv_dpath #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] rdata,
    input  logic              corr,
    input  logic              uncorr,
    output logic [WORD_W-1:0] wdata,
    output logic              ev_valid,
    output logic              ev_uncorr,
    output logic [ADDR_W-1:0] ev_addr
);
    logic [WORD_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            ev_valid  <= 1'b0;
            ev_uncorr <= 1'b0;
            ev_addr   <= '0;
        end else begin
            ev_valid <= take && (corr || uncorr);
            if (take) begin
                held      <= rdata;
                ev_uncorr <= uncorr;
                ev_addr   <= addr;
            end
        end
    end

    assign wdata = ~held;
endmodule

// File: rtl/nd_inv_bist.sv
module nd_inv_bist
    import nd_inv_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] range_lo,
    input  logic [ADDR_W-1:0] range_hi,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              ecc_corr,
    input  logic              ecc_uncorr,
    output logic              err_valid,
    output logic              err_uncorr,
    output logic [ADDR_W-1:0] err_addr
);
    step_e step;
    ctl_t  ctl;
    logic  at_last;
    logic  accept;

    assign accept = start && (step == ST_IDLE);

    nd_inv_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .empty   (range_lo > range_hi),
        .at_last (at_last),
        .step    (step),
        .ctl     (ctl)
    );

    nd_inv_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    ((step == ST_WR2) && !at_last),
        .lo      (range_lo),
        .hi      (range_hi),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    nd_inv_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .take      (ctl.take),
        .addr      (mem_addr),
        .rdata     (mem_rdata),
        .corr      (ecc_corr),
        .uncorr    (ecc_uncorr),
        .wdata     (mem_wdata),
        .ev_valid  (err_valid),
        .ev_uncorr (err_uncorr),
        .ev_addr   (err_addr)
    );

    assign mem_en = ctl.req;
    assign mem_we = ctl.wr;
    assign busy   = ctl.busy;
    assign done   = ctl.fin;
endmodule

// File: rtl/nd_inv_bist_chk.sv
module nd_inv_bist_chk #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] range_lo,
    input logic [ADDR_W-1:0] range_hi,
    input logic              busy,
    input logic              done,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              ecc_corr,
    input logic              ecc_uncorr,
    input logic              err_valid,
    input logic              err_uncorr
);
    p_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr >= range_lo) && (mem_addr <= range_hi));

    p_addr_walk_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we && $past(mem_en && mem_we)) |->
            (mem_addr == $past(mem_addr)) || (mem_addr == $past(mem_addr) + 1'b1));

    p_write_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |->
            $past(mem_en, 2) && !$past(mem_we, 2) && ($past(mem_addr, 2) == mem_addr));

    p_inverted_write_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> (mem_wdata == ~$past(mem_rdata)));

    p_event_source_r5: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(ecc_corr || ecc_uncorr));

    p_event_type_r5: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_uncorr) |-> $past(ecc_uncorr));

    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind nd_inv_bist nd_inv_bist_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .range_lo   (range_lo),
    .range_hi   (range_hi),
    .busy       (busy),
    .done       (done),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .ecc_corr   (ecc_corr),
    .ecc_uncorr (ecc_uncorr),
    .err_valid  (err_valid),
    .err_uncorr (err_uncorr)
);

// File: tb/sim_nd_inv_bist.sv
module sim_nd_inv_bist;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int WW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] range_lo = '0, range_hi = '0;
    logic          busy, done, mem_en, mem_we, err_valid, err_uncorr;
    logic [AW-1:0] mem_addr, err_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata = '0;
    logic          ecc_corr, ecc_uncorr;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    nd_inv_bist #(.ADDR_W(AW), .WORD_W(WW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .range_lo(range_lo), .range_hi(range_hi),
        .busy(busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr),
        .err_valid(err_valid), .err_uncorr(err_uncorr), .err_addr(err_addr)
    );

    // Memory model with stuck-at cells, and a triplicated-data code.
    logic [WW-1:0] mem   [DEPTH];
    logic [WW-1:0] smask [DEPTH];
    logic [WW-1:0] sval  [DEPTH];
    logic [WW-1:0] pre   [DEPTH];
    int            evseen[DEPTH];

    function automatic logic [WW-1:0] seen(int a, logic [WW-1:0] w);
        return (w & ~smask[a]) | (sval[a] & smask[a]);
    endfunction

    // 0 clean, 1 correctable, 2 uncorrectable
    function automatic int ecc_class(logic [WW-1:0] w);
        logic [3:0] diff;
        diff = (w[3:0] ^ w[7:4]) | (w[3:0] ^ w[11:8]);
        if ($countones(diff) == 0) return 0;
        if ($countones(diff) == 1) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= seen(int'(mem_addr), mem[mem_addr]);
        end
    end

    assign ecc_corr   = (ecc_class(mem_rdata) == 1);
    assign ecc_uncorr = (ecc_class(mem_rdata) == 2);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues
    typedef struct { logic we; logic [AW-1:0] a; logic [WW-1:0] d; } acc_t;
    typedef struct { logic [AW-1:0] a; logic unc; } ev_t;
    acc_t exp_acc[$];
    ev_t  exp_ev[$];

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_en) begin
                if (exp_acc.size() == 0) begin
                    chk(1'b0, "R1", "unexpected access at addr", longint'(mem_addr), 0);
                end else begin
                    acc_t e;
                    e = exp_acc.pop_front();
                    chk(mem_we == e.we, "R2", "access kind", longint'(mem_we), longint'(e.we));
                    chk(mem_addr == e.a, "R1", "access address", longint'(mem_addr), longint'(e.a));
                    if (e.we)
                        chk(mem_wdata == e.d, "R3", "inverted write data",
                            longint'(mem_wdata), longint'(e.d));
                end
            end
            if (err_valid) begin
                evseen[err_addr]++;
                if (exp_ev.size() == 0) begin
                    chk(1'b0, "R5", "unexpected error event at addr", longint'(err_addr), 0);
                end else begin
                    ev_t v;
                    v = exp_ev.pop_front();
                    chk(err_addr == v.a, "R5", "event address", longint'(err_addr), longint'(v.a));
                    chk(err_uncorr == v.unc, "R5", "event type",
                        longint'(err_uncorr), longint'(v.unc));
                end
            end
        end
    end

    task automatic run(int lo, int hi, bit extra_start);
        int n;
        int words;
        words = (lo <= hi) ? (hi - lo + 1) : 0;
        for (int a = lo; a <= hi; a++) begin
            logic [WW-1:0] r1, r2;
            pre[a] = seen(a, mem[a]);
            evseen[a] = 0;
            r1 = seen(a, mem[a]);
            exp_acc.push_back('{1'b0, AW'(a), '0});
            if (ecc_class(r1) != 0) exp_ev.push_back('{AW'(a), ecc_class(r1) == 2});
            exp_acc.push_back('{1'b1, AW'(a), ~r1});
            r2 = seen(a, ~r1);
            exp_acc.push_back('{1'b0, AW'(a), '0});
            if (ecc_class(r2) != 0) exp_ev.push_back('{AW'(a), ecc_class(r2) == 2});
            exp_acc.push_back('{1'b1, AW'(a), ~r2});
        end
        @(negedge clk);
        range_lo = AW'(lo);
        range_hi = AW'(hi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (words > 0) chk(busy == 1'b1, "R6", "busy after start", longint'(busy), 1);
        while (!done && n < 5000) begin
            if (busy != 1'b1) chk(1'b0, "R6", "busy dropped early", longint'(busy), 1);
            if (extra_start && n == 3) start = 1'b1;
            if (extra_start && n == 4) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == 6 * words + 1, "R7", "cycles to done", n, 6 * words + 1);
        chk(busy == 1'b0, "R6", "busy while done", longint'(busy), 0);
        if (extra_start)
            chk(n == 6 * words + 1, "R8", "second start changed timing", n, 6 * words + 1);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done pulse width", longint'(done), 0);
        chk(exp_acc.size() == 0, "R2", "missing accesses", exp_acc.size(), 0);
        chk(exp_ev.size() == 0, "R5", "missing error events", exp_ev.size(), 0);
        for (int a = lo; a <= hi; a++)
            chk(seen(a, mem[a]) == pre[a], "R4", "content restored",
                longint'(seen(a, mem[a])), longint'(pre[a]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            logic [3:0] d;
            d = 4'((a * 7 + 3) & 15);
            mem[a]   = {d, d, d};
            smask[a] = '0;
            sval[a]  = '0;
            evseen[a] = 0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !mem_en && !err_valid, "R9", "outputs in reset",
            longint'({busy, done, mem_en, err_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_en && !err_valid, "R9", "outputs after reset",
            longint'({busy, done, mem_en, err_valid}), 0);

        // Clean range
        run(4, 9, 1'b0);

        // Stuck cell opposite the stored bit (first read fails) and equal (second read fails)
        smask[20][5] = 1'b1; sval[20][5] = ~mem[20][5];
        smask[22][2] = 1'b1; sval[22][2] =  mem[22][2];
        run(18, 24, 1'b0);
        chk(evseen[20] == 1, "R10", "events for stuck word 20", evseen[20], 1);
        chk(evseen[22] == 1, "R10", "events for stuck word 22", evseen[22], 1);

        // Two stuck cells in one word: uncorrectable
        smask[30][1] = 1'b1; sval[30][1] = ~mem[30][1];
        smask[30][6] = 1'b1; sval[30][6] = ~mem[30][6];
        run(30, 31, 1'b0);
        chk(evseen[30] >= 1, "R5", "uncorrectable word reported", evseen[30], 1);

        // Inverted bounds: no access, done at once
        run(10, 5, 1'b0);

        // Single word at the top address
        run(63, 63, 1'b0);

        // Start while busy
        run(40, 43, 1'b1);

        // Whole memory
        run(0, 63, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule